// File: doc/BRIEF.md
# Multiplexed Parallel Converter Read Sequencer

This block sits on the host side of an 8-bit multiplexed parallel converter. It owns the converter's chip-select strobe, read strobe and channel address lines. For each accepted channel request it runs one read cycle, watches the converter's active-low interrupt and its open-drain ready line, captures the data byte and hands the byte on with the number of the channel that produced it. Timing is counted in system clock cycles.

A configuration input picks one of two access styles for each request. In stretched mode the read strobe stays low until the converter releases ready, and the byte on the bus then belongs to the channel that was just addressed. In pipelined mode every read is a short fixed pulse that starts a new conversion and returns the result of the one before it. The block therefore keeps the previous channel number as a tag, drops the first pipelined byte after reset or after a mode switch as stale, and keeps successive pipelined reads a minimum number of cycles apart. A stretched read that never ends is abandoned after a programmable number of cycles and an error pulse is raised.

Top module: `adcrc_ctrl`

## Requirements
- R1: During and after reset both strobes are high (inactive), `out_valid` and `err_timeout` are low, and once reset is released with no conversion pending `req_ready` is high.
- R2: A request is accepted when `req_valid` and `req_ready` are both high; the channel number is driven as a plain binary value on `adc_addr` at least `SETUP_CYC` cycles before the strobes fall, and it stays unchanged while chip select is low.
- R3: In stretched mode (`cfg_pipe` = 0) the strobes stay low until ready has been seen low and then released; the byte on `adc_data` at that point is delivered with `out_chan` equal to the addressed channel, and the conversion has ended before the strobes rise.
- R4: In stretched mode, if the read has not ended `cfg_timeout` cycles after the strobes fell, the strobes are raised, `err_timeout` is high for exactly one cycle and no byte is delivered.
- R5: In pipelined mode (`cfg_pipe` = 1) the strobes are low for exactly `PULSE_CYC` cycles; the byte captured is the previous conversion's result and carries the channel number of the previous pipelined read.
- R6: The first pipelined read after reset, and the first pipelined read after a request in the other mode, delivers no byte.
- R7: Two pipelined reads in a row have their chip-select falling edges at least `SPACE_CYC` cycles apart.
- R8: After a pipelined read or an abandoned stretched read, no new read starts until the converter's interrupt has gone low.
- R9: After a stretched read ends, the strobes stay high for at least `GAP_CYC` cycles before the next read.
- R10: A delivered byte stays on `out_valid`, `out_data` and `out_chan` unchanged until `out_ready` is high, and no request is accepted meanwhile.
- R11: Chip select and read fall together and rise together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pipe | input | 1 | Access style for the next request: 0 stretched, 1 pipelined |
| cfg_timeout | input | TO_W | Cycle limit for a stretched read |
| req_valid | input | 1 | Channel request present |
| req_chan | input | CH_W | Requested channel, binary 0..CHANNELS-1 |
| req_ready | output | 1 | Request can be accepted this cycle |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_addr | output | CH_W | Converter channel address |
| adc_int_n | input | 1 | Converter end-of-conversion interrupt, active low |
| adc_rdy | input | 1 | Converter ready line as seen through its pull-up: 0 held low, 1 released |
| adc_data | input | DATA_W | Converter data bus |
| out_valid | output | 1 | Captured byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | DATA_W | Captured byte |
| out_chan | output | CH_W | Channel the byte was converted from |
| err_timeout | output | 1 | One-cycle pulse when a stretched read is abandoned |

## Verification
The bench builds the block with eight channels, a one-cycle address setup, a three-cycle pipelined pulse, a 20-cycle pipelined spacing, a 5-cycle stretched gap and an 8-bit timeout. The short spacing lets the behavioural converter model run a 40-cycle conversion that outlasts it, so the interrupt gate of R8 decides when the next read starts instead of the spacing counter. With the 8-bit limit set to 30 against a 200-cycle conversion, the abandoned read of R4 is reached quickly, and the long conversion it leaves behind then tests the gate again before a stalled-output read closes the run.

// File: rtl/adcrc_pkg.sv
package adcrc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } rd_state_e;

endpackage

// File: rtl/adcrc_sync.sv
// Multi-bit level synchronizer, one flop chain per bit.
module adcrc_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/adcrc_timer.sv
// Loadable down counter; done while the count is zero.
module adcrc_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/adcrc_tag.sv
// Remembers which channel the converter is holding a result for (R5, R6).
module adcrc_tag #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc,
  input  logic            acc_pipe,
  input  logic            shift,
  input  logic [CH_W-1:0] cur_chan,
  output logic [CH_W-1:0] prev_chan,
  output logic            prev_ok
);

  logic last_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_chan <= '0;
      prev_ok   <= 1'b0;
      last_pipe <= 1'b0;
    end else if (acc) begin
      last_pipe <= acc_pipe;
      if (acc_pipe != last_pipe) prev_ok <= 1'b0;
    end else if (shift) begin
      prev_chan <= cur_chan;
      prev_ok   <= 1'b1;
    end
  end

endmodule

// File: rtl/adcrc_ctrl.sv
module adcrc_ctrl
  import adcrc_pkg::*;
#(
  parameter int CHANNELS    = 8,
  parameter int DATA_W      = 8,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 4,
  parameter int SPACE_CYC   = 125,
  parameter int GAP_CYC     = 25,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_pipe,
  input  logic [TO_W-1:0]   cfg_timeout,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  output logic              req_ready,
  output logic              adc_cs_n,
  output logic              adc_rd_n,
  output logic [CH_W-1:0]   adc_addr,
  input  logic              adc_int_n,
  input  logic              adc_rdy,
  input  logic [DATA_W-1:0] adc_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CH_W-1:0]   out_chan,
  output logic              err_timeout
);

  localparam int HOLD_MAX = (SPACE_CYC > GAP_CYC) ? SPACE_CYC : GAP_CYC;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);
  localparam int FIX_MAX  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int FIX_W    = $clog2(FIX_MAX + 1);
  localparam int STEP_W   = (TO_W > FIX_W) ? TO_W : FIX_W;

  rd_state_e         st;
  logic              mode_q;
  logic              pend_q;
  logic              seen_low_q;
  logic [1:0]        sync_d, sync_q;
  logic              int_s, rdy_s;
  logic              step_ld, step_done;
  logic [STEP_W-1:0] step_val;
  logic              hold_ld, hold_done;
  logic [HOLD_W-1:0] hold_val;
  logic              accept, shift, end_ok, abort;
  logic [CH_W-1:0]   prev_chan;
  logic              prev_ok;

  // Converter status lines arrive asynchronously.
  assign sync_d = {adc_rdy, adc_int_n};

  adcrc_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk(clk), .rst(rst), .d(sync_d), .q(sync_q)
  );

  assign int_s = sync_q[0];
  assign rdy_s = sync_q[1];

  // Per-state cycle count: setup, pulse width or timeout.
  adcrc_timer #(.W(STEP_W)) u_step (
    .clk(clk), .rst(rst), .load(step_ld), .val(step_val), .done(step_done)
  );

  // Hold-off between reads: start spacing (pipelined) or end gap (stretched).
  adcrc_timer #(.W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .load(hold_ld), .val(hold_val), .done(hold_done)
  );

  adcrc_tag #(.CH_W(CH_W)) u_tag (
    .clk(clk), .rst(rst), .acc(accept), .acc_pipe(cfg_pipe), .shift(shift),
    .cur_chan(adc_addr), .prev_chan(prev_chan), .prev_ok(prev_ok)
  );

  // R8, R10: wait for the hold-off, a free output slot and a finished conversion.
  assign req_ready = (st == ST_IDLE) && hold_done && !out_valid && (!pend_q || !int_s);
  assign accept    = req_valid && req_ready;

  // R3: end only after ready was seen held low and then released.
  assign end_ok = (st == ST_STROBE) && !mode_q && seen_low_q && rdy_s;
  assign abort  = (st == ST_STROBE) && !mode_q && !end_ok && step_done;
  assign shift  = (st == ST_STROBE) && mode_q && step_done;

  always_comb begin
    step_ld  = 1'b0;
    step_val = '0;
    hold_ld  = 1'b0;
    hold_val = '0;
    unique case (st)
      ST_IDLE: begin
        if (accept) begin
          step_ld  = 1'b1;
          step_val = STEP_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (step_done) begin
          step_ld = 1'b1;
          if (mode_q) begin
            step_val = STEP_W'(PULSE_CYC - 1);
            hold_ld  = 1'b1;
            hold_val = HOLD_W'(SPACE_CYC);
          end else begin
            step_val = STEP_W'(cfg_timeout);
          end
        end
      end
      ST_STROBE: begin
        if (end_ok || abort) begin
          hold_ld  = 1'b1;
          hold_val = HOLD_W'(GAP_CYC);
        end
      end
      default: begin
        step_ld = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      adc_cs_n    <= 1'b1;
      adc_rd_n    <= 1'b1;
      adc_addr    <= '0;
      mode_q      <= 1'b0;
      pend_q      <= 1'b0;
      seen_low_q  <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_chan    <= '0;
      err_timeout <= 1'b0;
    end else begin
      err_timeout <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            adc_addr <= req_chan;
            mode_q   <= cfg_pipe;
            pend_q   <= 1'b0;
            st       <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (step_done) begin
            adc_cs_n   <= 1'b0;
            adc_rd_n   <= 1'b0;
            seen_low_q <= 1'b0;
            st         <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (mode_q) begin
            if (step_done) begin
              adc_cs_n <= 1'b1;
              adc_rd_n <= 1'b1;
              pend_q   <= 1'b1;
              st       <= ST_IDLE;
              if (prev_ok) begin
                out_valid <= 1'b1;
                out_data  <= adc_data;
                out_chan  <= prev_chan;
              end
            end
          end else begin
            if (!rdy_s) seen_low_q <= 1'b1;
            if (end_ok) begin
              adc_cs_n  <= 1'b1;
              adc_rd_n  <= 1'b1;
              out_valid <= 1'b1;
              out_data  <= adc_data;
              out_chan  <= adc_addr;
              st        <= ST_IDLE;
            end else if (abort) begin
              adc_cs_n    <= 1'b1;
              adc_rd_n    <= 1'b1;
              err_timeout <= 1'b1;
              pend_q      <= 1'b1;
              st          <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adcrc_ctrl_chk.sv
module adcrc_ctrl_chk #(
  parameter int CH_W      = 3,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 4,
  parameter int SPACE_CYC = 125
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic [CH_W-1:0]   addr,
  input logic              req_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CH_W-1:0]   out_chan,
  input logic              err,
  input logic              mode_q
);

  localparam int LW = $clog2(PULSE_CYC + 2);
  localparam int SW = $clog2(SPACE_CYC + 1);

  logic          prev_cs;
  logic [LW-1:0] low_cnt;
  logic [SW-1:0] since;
  logic          last_fall_pipe;
  logic          fall;

  assign fall = !cs_n && prev_cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cs        <= 1'b1;
      low_cnt        <= '0;
      since          <= SW'(SPACE_CYC);
      last_fall_pipe <= 1'b0;
    end else begin
      prev_cs <= cs_n;
      if (!cs_n) begin
        if (low_cnt != LW'(PULSE_CYC + 1)) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
      if (fall) begin
        since          <= SW'(1);
        last_fall_pipe <= mode_q;
      end else if (since != SW'(SPACE_CYC)) begin
        since <= since + 1'b1;
      end
    end
  end

  p_strobes_paired_r11: assert property (@(posedge clk) disable iff (rst)
    cs_n == rd_n);

  p_addr_held_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n)) |-> $stable(addr));

  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

  p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !req_ready);

  p_err_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  p_err_ends_read_r4: assert property (@(posedge clk) disable iff (rst)
    err |-> (cs_n && !$past(cs_n)));

  p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q && cs_n && !prev_cs) |-> (low_cnt == LW'(PULSE_CYC)));

  p_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    (fall && mode_q && last_fall_pipe) |-> (since >= SW'(SPACE_CYC)));

endmodule

bind adcrc_ctrl adcrc_ctrl_chk #(
  .CH_W(CH_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC), .SPACE_CYC(SPACE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(adc_cs_n), .rd_n(adc_rd_n), .addr(adc_addr),
  .req_ready(req_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_chan(out_chan), .err(err_timeout), .mode_q(mode_q)
);

// File: tb/adcrc_ctrl_test.sv
module adcrc_ctrl_test;

  localparam int CH = 8, CW = 3, DW = 8, SETUP = 1, PULSE = 3, SPACE = 20, GAP = 5, TOW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic           cfg_pipe = 1'b0;
  logic [TOW-1:0] cfg_timeout = 8'd100;
  logic           req_valid = 1'b0;
  logic [CW-1:0]  req_chan = '0;
  logic           req_ready;
  logic           cs_n, rd_n;
  logic [CW-1:0]  addr;
  logic           int_n_m = 1'b1;
  logic           rdy_m;
  logic [DW-1:0]  data_m;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [DW-1:0]  out_data;
  logic [CW-1:0]  out_chan;
  logic           err;

  adcrc_ctrl #(
    .CHANNELS(CH), .DATA_W(DW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
    .SPACE_CYC(SPACE), .GAP_CYC(GAP), .TO_W(TOW)
  ) uut (
    .clk(clk), .rst(rst), .cfg_pipe(cfg_pipe), .cfg_timeout(cfg_timeout),
    .req_valid(req_valid), .req_chan(req_chan), .req_ready(req_ready),
    .adc_cs_n(cs_n), .adc_rd_n(rd_n), .adc_addr(addr),
    .adc_int_n(int_n_m), .adc_rdy(rdy_m), .adc_data(data_m),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .err_timeout(err)
  );

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural converter model and expected-result queue.
  int          conv_cyc = 12;
  logic        busy = 1'b0;
  int          cnt = 0;
  logic [CW-1:0] conv_ch = '0;
  logic [DW-1:0] result = '0;
  int          idx = 0;
  logic        cs_prev = 1'b1;
  bit          prev_ok = 0;
  logic [CW-1:0] prev_ch = '0;
  bit          last_mode = 0;
  logic [CW+DW:0] expq[$];

  function automatic logic [DW-1:0] cval(input int c, input int k);
    return DW'((c * 37 + k * 11 + 5) & 255);
  endfunction

  assign rdy_m  = !(!cs_n && busy);
  assign data_m = result;

  always @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; int_n_m <= 1'b1; result <= '0; cs_prev <= 1'b1;
      idx = 0; prev_ok = 0; last_mode = 0;
    end else begin
      cs_prev <= cs_n;
      if (cs_n && !cs_prev) int_n_m <= 1'b1;
      if (!cs_n && cs_prev) begin
        busy <= 1'b1; cnt <= conv_cyc; conv_ch <= addr;
        if (cfg_pipe) begin
          if (!last_mode) prev_ok = 0;
          if (prev_ok) expq.push_back({1'b1, prev_ch, result});
          prev_ch = addr;
          prev_ok = 1;
        end
        last_mode = cfg_pipe;
      end else if (busy) begin
        if (cnt <= 1) begin
          logic [DW-1:0] v;
          v = cval(int'(conv_ch), idx);
          idx = idx + 1;
          busy <= 1'b0; result <= v; int_n_m <= 1'b0;
          if (!cs_n) expq.push_back({1'b0, conv_ch, v});
        end else begin
          cnt <= cnt - 1;
        end
      end
    end
  end

  // Cycle monitor, sampled on the falling edge.
  int deliv = 0, errs = 0, falls = 0, since = 0, high_run = 0, cycles = 0;
  bit have_fall = 0, last_fall_pipe = 0, exp_to = 0;
  logic mon_cs = 1'b1;
  logic [CW-1:0] exp_chan = '0;
  logic [CW+DW:0] e;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (!rst) begin
      since++;
      if (cs_n) high_run++;
      if (err) errs++;
      if (!cs_n && mon_cs) begin
        falls++;
        check(rd_n == 1'b0, "R11 strobes fall together", int'(rd_n), 0);
        check(addr == exp_chan, "R2 address at strobe", int'(addr), int'(exp_chan));
        check(busy == 1'b0, "R8 prior conversion finished", int'(busy), 0);
        if (have_fall && cfg_pipe && last_fall_pipe)
          check(since >= SPACE, "R7 pipelined spacing", since, SPACE);
        if (have_fall && !cfg_pipe && !last_fall_pipe)
          check(high_run >= GAP, "R9 stretched gap", high_run, GAP);
        since = 0; high_run = 0; have_fall = 1; last_fall_pipe = cfg_pipe;
      end
      if (cs_n && !mon_cs) begin
        check(rd_n == 1'b1, "R11 strobes rise together", int'(rd_n), 1);
        if (!cfg_pipe && !exp_to)
          check(busy == 1'b0, "R3 read held to conversion end", int'(busy), 0);
      end
      mon_cs = cs_n;
      if (out_valid && out_ready) begin
        deliv++;
        if (expq.size() == 0) begin
          check(0, "R6 unexpected byte", int'(out_chan), -1);
        end else begin
          e = expq.pop_front();
          check(out_chan == e[CW+DW-1:DW], e[CW+DW] ? "R5 pipelined tag" : "R3 stretched tag",
                int'(out_chan), int'(e[CW+DW-1:DW]));
          check(out_data == e[DW-1:0], e[CW+DW] ? "R5 pipelined data" : "R3 stretched data",
                int'(out_data), int'(e[DW-1:0]));
        end
      end
    end
  end

  task automatic do_req(input int c);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_chan = CW'(c); exp_chan = CW'(c);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [DW-1:0] held;
  int f0;

  initial begin
    settle(3);
    check(cs_n && rd_n, "R1 strobes idle in reset", int'(cs_n), 1);
    check(!out_valid && !err, "R1 outputs quiet in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);

    // Stretched reads.
    do_req(0); do_req(3); do_req(7); do_req(5);
    settle(100);
    check(deliv == 4, "R3 stretched bytes delivered", deliv, 4);

    // Pipelined reads: first one is stale.
    cfg_pipe = 1'b1;
    do_req(1); do_req(2); do_req(6); do_req(4); do_req(0);
    settle(100);
    check(deliv == 8, "R6 first pipelined byte dropped", deliv, 8);

    // Conversion longer than the spacing: interrupt gates the next read.
    conv_cyc = 40;
    do_req(3); do_req(5);
    settle(200);
    check(deliv == 10, "R8 gated pipelined reads delivered", deliv, 10);

    // Mode switch invalidates the tag.
    conv_cyc = 12;
    cfg_pipe = 1'b0;
    do_req(2);
    settle(60);
    cfg_pipe = 1'b1;
    do_req(7); do_req(1);
    settle(100);
    check(deliv == 12, "R6 byte dropped after mode switch", deliv, 12);

    // Stretched read that never ends in time.
    cfg_pipe = 1'b0; cfg_timeout = 8'd30; conv_cyc = 200; exp_to = 1;
    do_req(4);
    settle(100);
    check(errs == 1, "R4 timeout error pulse", errs, 1);
    check(deliv == 12, "R4 no byte after timeout", deliv, 12);
    exp_to = 0; conv_cyc = 12; cfg_timeout = 8'd100;

    // Output stall.
    out_ready = 1'b0;
    do_req(6);
    while (!out_valid) @(negedge clk);
    held = out_data; f0 = falls;
    settle(30);
    check(out_valid && out_data == held, "R10 byte held while stalled", int'(out_data), int'(held));
    check(!req_ready && falls == f0, "R10 no new read while stalled", falls, f0);
    out_ready = 1'b1;
    settle(50);
    check(deliv == 13, "R10 byte delivered after stall", deliv, 13);
    check(expq.size() == 0, "R3 all expected bytes seen", expq.size(), 0);
    check(errs == 1, "R4 single error overall", errs, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule